// File: doc/BRIEF.md
# Page-Mode Chip-Select Wait Controller

This block sets the length of each bus cycle on one external chip-select channel that supports page-mode bursts. A bus master asks for a cycle with `req`, states its direction with `rnw` (1 = read, 0 = write), and uses `burst_continue` to mark a cycle that follows the previous one inside the same page burst. The block picks a wait count for the cycle, holds the cycle for that many clocks plus one, and then gives a single-clock `done` strobe.

Two registers set the timing. A control register carries the channel enable. A wait register holds four 3-bit wait counts, one each for first reads, first writes, page reads and page writes, plus an enable for page reads and one for page writes. A page count replaces the normal count only on a later cycle of a burst, and only when the enable for that direction is set. A page count programmed above its normal count is cut down to the normal count. On every channel but channel 0, the wait register refuses writes while the channel is enabled and reports each refused write.

Top module: `pgcs_wait_ctrl`

## Requirements
- R1: After reset the wait register (address 1) reads 0x01FF07, so all four wait fields hold 7 and both page enables are 0. The control register (address 0) reads 0, and `done` and `reg_wr_err` are low.
- R2: The wait register holds the page write count in bits [2:0], the page read count in [10:8], the normal write count in [13:11], the normal read count in [16:14], the page write enable in bit 17 and the page read enable in bit 18. A count of c gives c wait states, from 0 to 7. When a request is sampled on a clock edge, `done` goes high on the edge w+1 clocks later, where w is the chosen wait count.
- R3: A cycle counts as a later cycle only when `burst_continue` is 1 and a cycle has already completed since reset. Any other cycle is a first cycle and uses the normal count for its direction. A later read with the page read enable set uses the page read count. A later write with the page write enable set uses the page write count.
- R4: When the page enable for a direction is 0, later cycles in that direction use the normal count.
- R5: A page count greater than the normal count for the same direction acts as the normal count.
- R6: Bits [7:3] and [23:19] of the wait register and bits [23:1] of the control register always read 0. Values written to them have no effect.
- R7: On a channel with a non-zero `CHAN_ID`, a write to the wait register while the channel is enabled leaves the register unchanged. `reg_wr_err` is then high for exactly the one clock after that write.
- R8: On channel 0 (`CHAN_ID` = 0), writes to the wait register take effect while the channel is enabled, and `reg_wr_err` stays low.
- R9: A request is accepted only while the channel is enabled and no cycle is in progress. Other requests produce no `done`.
- R10: `done` is high for one clock per accepted request. A request sampled on the same edge as a write that disables the channel is still accepted and completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = control, 1 = wait |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read data of the selected register |
| reg_wr_err | output | 1 | One-clock pulse after a refused write |
| req | input | 1 | Bus cycle request |
| rnw | input | 1 | Cycle direction, 1 = read |
| burst_continue | input | 1 | Request continues the current page burst |
| done | output | 1 | One-clock cycle-complete strobe |

## Verification
Two events can fall on the same clock edge: a register write that clears the channel enable, and the sampling of a bus request. The bench drives both in the same cycle. It expects the request to be accepted using the enable value from before the edge, expects `done` after the full wait count, and then reads the control register back as 0. A scoreboard holds the cycle in which each `done` is due. It flags any strobe that arrives early, arrives late or has no matching request. This is how requests made while the block is busy or the channel is off are shown to be ignored.

// File: rtl/pgcs_pkg.sv
package pgcs_pkg;

    localparam int WAIT_W  = 3;
    localparam int REG_W   = 24;
    localparam int ADDR_W  = 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_WAIT = 1'b1;

    // wait register field positions
    localparam int PG_WR_LSB   = 0;
    localparam int PG_RD_LSB   = 8;
    localparam int NRM_WR_LSB  = 11;
    localparam int NRM_RD_LSB  = 14;
    localparam int PG_WR_EN_BT = 17;
    localparam int PG_RD_EN_BT = 18;

    localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

    typedef struct packed {
        logic              pg_rd_en;
        logic              pg_wr_en;
        logic [WAIT_W-1:0] nrm_rd;
        logic [WAIT_W-1:0] nrm_wr;
        logic [WAIT_W-1:0] pg_rd;
        logic [WAIT_W-1:0] pg_wr;
    } wait_cfg_t;

    localparam int CFG_BITS = $bits(wait_cfg_t);

    localparam wait_cfg_t CFG_RESET = '{
        pg_rd_en: 1'b0, pg_wr_en: 1'b0,
        nrm_rd: WAIT_MAX, nrm_wr: WAIT_MAX,
        pg_rd: WAIT_MAX, pg_wr: WAIT_MAX
    };

    typedef enum logic [0:0] {
        T_IDLE = 1'b0,
        T_BUSY = 1'b1
    } tmr_state_e;

    function automatic wait_cfg_t unpack_cfg(input logic [REG_W-1:0] v);
        wait_cfg_t c;
        c.pg_wr    = v[PG_WR_LSB  +: WAIT_W];
        c.pg_rd    = v[PG_RD_LSB  +: WAIT_W];
        c.nrm_wr   = v[NRM_WR_LSB +: WAIT_W];
        c.nrm_rd   = v[NRM_RD_LSB +: WAIT_W];
        c.pg_wr_en = v[PG_WR_EN_BT];
        c.pg_rd_en = v[PG_RD_EN_BT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input wait_cfg_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[PG_WR_LSB  +: WAIT_W] = c.pg_wr;
        v[PG_RD_LSB  +: WAIT_W] = c.pg_rd;
        v[NRM_WR_LSB +: WAIT_W] = c.nrm_wr;
        v[NRM_RD_LSB +: WAIT_W] = c.nrm_rd;
        v[PG_WR_EN_BT]          = c.pg_wr_en;
        v[PG_RD_EN_BT]          = c.pg_rd_en;
        return v;
    endfunction

    function automatic logic [WAIT_W-1:0] clamp_wait(
        input logic [WAIT_W-1:0] page_w,
        input logic [WAIT_W-1:0] norm_w
    );
        return (page_w > norm_w) ? norm_w : page_w;
    endfunction

endpackage

// File: rtl/pgcs_cfg_regs.sv
module pgcs_cfg_regs
    import pgcs_pkg::*;
#(
    parameter int CHAN_ID = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    output logic                wr_err,
    output wait_cfg_t           cfg,
    output logic                chan_en
);

    wait_cfg_t cfg_q;
    logic      chan_en_q;
    logic      wr_err_q;
    logic      lock_active;

    generate
        if (CHAN_ID == 0) begin : g_no_lock
            assign lock_active = 1'b0;
        end else begin : g_lock
            assign lock_active = chan_en_q;
        end
    endgenerate

    logic unused_rsv;
    assign unused_rsv = ^{wdata[7:3], wdata[23:19]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            chan_en_q <= 1'b0;
            wr_err_q  <= 1'b0;
        end else begin
            wr_err_q <= 1'b0;
            if (wr) begin
                if (addr == ADDR_CTRL) begin
                    chan_en_q <= wdata[0];
                end else if (lock_active) begin
                    wr_err_q <= 1'b1;
                end else begin
                    cfg_q <= unpack_cfg(wdata);
                end
            end
        end
    end

    always_comb begin
        if (addr == ADDR_WAIT) begin
            rdata = pack_cfg(cfg_q);
        end else begin
            rdata    = '0;
            rdata[0] = chan_en_q;
        end
    end

    assign wr_err  = wr_err_q;
    assign cfg     = cfg_q;
    assign chan_en = chan_en_q;

endmodule

// File: rtl/pgcs_wait_sel.sv
module pgcs_wait_sel
    import pgcs_pkg::*;
(
    input  wait_cfg_t          cfg,
    input  logic               rnw,
    input  logic               later,
    output logic [WAIT_W-1:0]  wait_cnt
);

    logic [WAIT_W-1:0] rd_page;
    logic [WAIT_W-1:0] wr_page;

    always_comb begin
        rd_page = clamp_wait(cfg.pg_rd, cfg.nrm_rd);
        wr_page = clamp_wait(cfg.pg_wr, cfg.nrm_wr);
        if (rnw) begin
            wait_cnt = (later && cfg.pg_rd_en) ? rd_page : cfg.nrm_rd;
        end else begin
            wait_cnt = (later && cfg.pg_wr_en) ? wr_page : cfg.nrm_wr;
        end
    end

endmodule

// File: rtl/pgcs_cycle_timer.sv
module pgcs_cycle_timer
    import pgcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               chan_en,
    input  logic               burst_continue,
    input  logic [WAIT_W-1:0]  wait_cnt,
    output logic               later,
    output logic               busy,
    output logic               done
);

    tmr_state_e        state_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              in_burst_q;
    logic              done_q;
    logic              accept;

    assign accept = (state_q == T_IDLE) && req && chan_en;
    assign later  = burst_continue && in_burst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= T_IDLE;
            cnt_q      <= '0;
            in_burst_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                T_IDLE: begin
                    if (accept) begin
                        state_q <= T_BUSY;
                        cnt_q   <= wait_cnt;
                    end
                end
                T_BUSY: begin
                    if (cnt_q == '0) begin
                        done_q     <= 1'b1;
                        in_burst_q <= 1'b1;
                        state_q    <= T_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= T_IDLE;
            endcase
        end
    end

    assign busy = (state_q == T_BUSY);
    assign done = done_q;

endmodule

// File: rtl/pgcs_wait_ctrl.sv
module pgcs_wait_ctrl
    import pgcs_pkg::*;
#(
    parameter int CHAN_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [23:0]       reg_wdata,
    output logic [23:0]       reg_rdata,
    output logic              reg_wr_err,
    input  logic              req,
    input  logic              rnw,
    input  logic              burst_continue,
    output logic              done
);

    wait_cfg_t         cfg_w;
    logic              chan_en_w;
    logic              later_w;
    logic              busy_w;
    logic [WAIT_W-1:0] wait_w;

    pgcs_cfg_regs #(.CHAN_ID(CHAN_ID)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .wr_err  (reg_wr_err),
        .cfg     (cfg_w),
        .chan_en (chan_en_w)
    );

    pgcs_wait_sel u_sel (
        .cfg      (cfg_w),
        .rnw      (rnw),
        .later    (later_w),
        .wait_cnt (wait_w)
    );

    pgcs_cycle_timer u_tmr (
        .clk            (clk),
        .rst            (rst),
        .req            (req),
        .chan_en        (chan_en_w),
        .burst_continue (burst_continue),
        .wait_cnt       (wait_w),
        .later          (later_w),
        .busy           (busy_w),
        .done           (done)
    );

endmodule

// File: rtl/pgcs_wait_ctrl_chk.sv
module pgcs_wait_ctrl_chk
    import pgcs_pkg::*;
#(
    parameter int CHAN_ID = 1
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr,
    input logic                reg_addr,
    input logic [REG_W-1:0]    reg_rdata,
    input logic                reg_wr_err,
    input logic                done,
    input logic                chan_en,
    input logic                busy,
    input logic [CFG_BITS-1:0] cfg_flat
);

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    wr_err_source_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_err |-> $past(reg_wr && (reg_addr == ADDR_WAIT) && chan_en));

    // R7
    blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == ADDR_WAIT) && chan_en && (CHAN_ID != 0))
        |=> $stable(cfg_flat));

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_WAIT) |-> (reg_rdata[7:3] == '0 && reg_rdata[23:19] == '0));

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R8
    ch0_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (CHAN_ID == 0) |-> !reg_wr_err);

endmodule

bind pgcs_wait_ctrl pgcs_wait_ctrl_chk #(.CHAN_ID(CHAN_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_wr_err (reg_wr_err),
    .done       (done),
    .chan_en    (chan_en_w),
    .busy       (busy_w),
    .cfg_flat   (cfg_w)
);

// File: tb/pgcs_wait_ctrl_test.sv
module pgcs_wait_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        reg_wr_err;
    logic        req = 1'b0;
    logic        rnw = 1'b0;
    logic        burst_continue = 1'b0;
    logic        done;

    logic        c0_wr = 1'b0;
    logic        c0_addr = 1'b0;
    logic [23:0] c0_wdata = '0;
    logic [23:0] c0_rdata;
    logic        c0_err;
    logic        c0_done;

    always #4 clk = ~clk;

    pgcs_wait_ctrl #(.CHAN_ID(1)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wr_err(reg_wr_err),
        .req(req), .rnw(rnw), .burst_continue(burst_continue), .done(done)
    );

    pgcs_wait_ctrl #(.CHAN_ID(0)) uut_ch0 (
        .clk(clk), .rst(rst), .reg_wr(c0_wr), .reg_addr(c0_addr),
        .reg_wdata(c0_wdata), .reg_rdata(c0_rdata), .reg_wr_err(c0_err),
        .req(1'b0), .rnw(1'b0), .burst_continue(1'b0), .done(c0_done)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int spurious = 0;

    typedef struct { int due; string tag; } exp_t;
    exp_t q[$];

    // bench model of the programmed register
    int m_nrd = 7, m_nwr = 7, m_prd = 7, m_pwr = 7;
    bit m_pre = 0, m_pwe = 0, m_in_burst = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard items as done strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                check(q[0].tag, {31'b0, done}, 32'd1);
                void'(q.pop_front());
            end else if (done === 1'b1) begin
                checks++;
                errors++;
                spurious++;
                $display("FAIL R9: unexpected done at cycle %0d (actual 1 expected 0)", cyc);
            end
        end
    end

    function automatic int model_wait(bit r, bit c);
        bit later;
        int pg;
        later = c && m_in_burst;
        if (r) begin
            pg = (m_prd > m_nrd) ? m_nrd : m_prd;
            return (later && m_pre) ? pg : m_nrd;
        end
        pg = (m_pwr > m_nwr) ? m_nwr : m_pwr;
        return (later && m_pwe) ? pg : m_nwr;
    endfunction

    function automatic void model_set(logic [23:0] v);
        m_pwr = int'(v[2:0]);
        m_prd = int'(v[10:8]);
        m_nwr = int'(v[13:11]);
        m_nrd = int'(v[16:14]);
        m_pwe = v[17];
        m_pre = v[18];
    endfunction

    task automatic reg_write(bit a, logic [23:0] d, output bit err);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        err = reg_wr_err;
    endtask

    task automatic reg_read(bit a, output logic [23:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // one bus cycle; extra=1 also pulses req again while busy
    task automatic bus_cycle(bit r, bit c, bit extra, string tag);
        int w;
        @(negedge clk);
        w = model_wait(r, c);
        req = 1'b1; rnw = r; burst_continue = c;
        q.push_back('{cyc + w + 2, tag});
        m_in_burst = 1;
        @(negedge clk);
        req = extra;
        @(negedge clk);
        req = 1'b0;
        repeat (w + 2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [23:0] rd;
        bit err;
        int sp;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(1'b1, rd);  check("R1 wait reg", {8'b0, rd}, 32'h01FF07);
        reg_read(1'b0, rd);  check("R1 ctrl reg", {8'b0, rd}, 32'h0);
        check("R1 done", {31'b0, done}, 0);
        check("R1 wr_err", {31'b0, reg_wr_err}, 0);

        // R2 R6: program with reserved bits set; nrd=5 nwr=2 prd=1 pwr=0 pre=1
        reg_write(1'b1, 24'hFD51F8, err);
        check("R7 no error while disabled", {31'b0, err}, 0);
        model_set(24'h055100);
        reg_read(1'b1, rd);  check("R6 R2 readback", {8'b0, rd}, 32'h055100);
        reg_write(1'b0, 24'hFFFFFF, err);
        reg_read(1'b0, rd);  check("R6 ctrl reserved", {8'b0, rd}, 32'h1);

        // R3 first cycle after reset with continue=1 is still a first cycle
        bus_cycle(1'b1, 1'b1, 1'b0, "R3 first read uses normal 5");
        bus_cycle(1'b1, 1'b1, 1'b0, "R3 later read uses page 1");
        bus_cycle(1'b0, 1'b1, 1'b0, "R4 later write page disabled 2");
        bus_cycle(1'b0, 1'b0, 1'b0, "R2 first write 2");
        // R9 request during busy ignored
        bus_cycle(1'b1, 1'b0, 1'b1, "R9 busy req ignored, read 5");

        // R7 blocked write while enabled
        reg_write(1'b1, 24'h000000, err);
        check("R7 wr_err pulse", {31'b0, err}, 1);
        @(negedge clk);
        check("R7 wr_err one clock", {31'b0, reg_wr_err}, 0);
        reg_read(1'b1, rd);  check("R7 value held", {8'b0, rd}, 32'h055100);

        // R10 disable on the same edge a request is sampled
        @(negedge clk);
        req = 1'b1; rnw = 1'b1; burst_continue = 1'b0;
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 24'h0;
        q.push_back('{cyc + model_wait(1'b1, 1'b0) + 2, "R10 request at disable edge"});
        @(negedge clk);
        req = 1'b0; reg_wr = 1'b0;
        repeat (8) @(negedge clk);
        reg_read(1'b0, rd);  check("R10 channel off", {8'b0, rd}, 32'h0);

        // R9 request while disabled ignored
        sp = spurious;
        @(negedge clk); req = 1'b1; rnw = 1'b0;
        @(negedge clk); req = 1'b0;
        repeat (12) @(negedge clk);
        check("R9 no done while disabled", sp, spurious);

        // R5 clamp: nrd=3 prd=6 nwr=0 pwr=7 both enables
        reg_write(1'b1, 24'h06C607, err);
        check("R7 write accepted when disabled", {31'b0, err}, 0);
        model_set(24'h06C607);
        reg_read(1'b1, rd);  check("R2 readback 2", {8'b0, rd}, 32'h06C607);
        reg_write(1'b0, 24'h000001, err);
        bus_cycle(1'b1, 1'b0, 1'b0, "R2 first read 3");
        bus_cycle(1'b1, 1'b1, 1'b0, "R5 page read clamped to 3");
        bus_cycle(1'b0, 1'b1, 1'b0, "R5 page write clamped to 0");
        bus_cycle(1'b0, 1'b1, 1'b0, "R10 back-to-back zero wait");

        // R8 channel 0 accepts writes while enabled
        @(negedge clk); c0_wr = 1'b1; c0_addr = 1'b0; c0_wdata = 24'h1;
        @(negedge clk); c0_addr = 1'b1; c0_wdata = 24'h000000;
        @(negedge clk); c0_wr = 1'b0;
        check("R8 ch0 no error", {31'b0, c0_err}, 0);
        #1 check("R8 ch0 value taken", {8'b0, c0_rdata}, 32'h0);

        repeat (4) @(negedge clk);
        check("R9 scoreboard drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule